// File: doc/BRIEF.md
# Multi-Cycle Multiplier with Pipeline Interlock

This block pairs a fixed-but-parameterised-latency unsigned integer multiplier with the stall and writeback control that a five-stage in-order pipeline needs around it. The execute stage offers two operands, a destination register index and an overflow-enable bit through a valid/ready start handshake. A start is accepted in the cycle where both `start_valid` and `start_ready` are high. While a multiply is in flight `start_ready` stays low. The execute stage must hold its request until it is accepted, and the stall output keeps it frozen anyway.

The product never reaches the ALU forwarding paths. It leaves the block only through the register-file write mux, which it owns for exactly one cycle. The memory stage is held until the product is due. Each cycle that the memory stage is frozen pushes a bubble into writeback. While the multiply is in flight, a hazard output tells decode whether its source registers name the pending destination, so that decode can insert bubbles.

Timing, with the accepting cycle called S and the latency parameter called L (at least 2): the block is busy in cycles S+1 to S+L. The stall output is high in cycles S+1 to S+L-2. Bubbles reach writeback in cycles S+2 to S+L-1. The product is written in cycle S+L.

Top module: `mul_interlock`

## Requirements
- R1: `start_ready` is high when idle and low in cycles S+1 through S+L. It is high again in S+L+1.
- R2: `stall` is high exactly in cycles S+1 through S+L-2, and is never high while idle. With L=2 there is no stall.
- R3: In cycle S+L, `rf_we` is high, `rf_waddr` equals the destination index given at S, and `rf_wdata` equals the low 32 bits of the unsigned product of the two operands.
- R4: A multiply whose destination index is 0 produces no register-file write in cycle S+L.
- R5: When no multiply result is due and no bubble is scheduled, the outputs `rf_we`, `rf_waddr` and `rf_wdata` follow `pipe_wb_valid`, `pipe_wb_rd` and `pipe_wb_data`. In the bubble cycles S+2 through S+L-1, `rf_we` is low whatever those inputs are. In cycle S+L the multiply result replaces them.
- R6: `hazard` is high when a nonzero destination index matches `dec_rs1` or `dec_rs2`. This holds for the accepting cycle S, using `start_rd`, and for cycles S+1 through S+L, using the latched index. `hazard` is low at all other times.
- R7: `mul_ovf` is high only in cycle S+L. It is high there exactly when `start_ovf_en` was high at S and the upper 32 bits of the 64-bit product are nonzero.
- R8: After reset, `start_ready` is high and `stall`, `hazard`, `rf_we` and `mul_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_valid | input | 1 | Execute stage offers a multiply |
| start_ready | output | 1 | Multiplier can accept a start |
| start_a | input | 32 | Operand A |
| start_b | input | 32 | Operand B |
| start_rd | input | 5 | Destination register index |
| start_ovf_en | input | 1 | Overflow reporting enabled for this multiply |
| dec_rs1 | input | 5 | Decode-stage source index 1 |
| dec_rs2 | input | 5 | Decode-stage source index 2 |
| pipe_wb_valid | input | 1 | Ordinary writeback request from the pipeline |
| pipe_wb_rd | input | 5 | Ordinary writeback register index |
| pipe_wb_data | input | 32 | Ordinary writeback data |
| stall | output | 1 | Freeze fetch, decode, execute and memory registers |
| hazard | output | 1 | Decode source depends on the pending product |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 5 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| mul_ovf | output | 1 | Overflow flag, valid with the product write |

## Verification
Several properties are checked on every cycle. The stall only appears while busy. The end of the product delay line lines up with the sequencer's completion cycle. A bubble cycle never writes the register file. A destination of register 0 never writes. The overflow flag appears only in the completion cycle. The bench scenarios cover the rest: the exact stall and bubble windows relative to the accepting cycle, the product values for wrapping and overflowing operands, hazard matching on each source port, and pass-through of ordinary writebacks outside the multiply window.

// File: rtl/mul_ilk_pkg.sv
package mul_ilk_pkg;
  localparam int XLEN   = 32;
  localparam int RIDX_W = 5;
  typedef logic [XLEN-1:0]   word_t;
  typedef logic [RIDX_W-1:0] ridx_t;
endpackage

// File: rtl/mul_seq.sv
module mul_seq #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic busy,
  output logic stall,
  output logic bubble,
  output logic done
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (fire) begin
      busy <= 1'b1;
      cnt  <= CW'(1);
    end else if (busy) begin
      if (cnt == CW'(LAT)) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  always_comb begin
    stall  = busy && (int'(cnt) <= LAT - 2);
    bubble = busy && (cnt >= CW'(2)) && (int'(cnt) <= LAT - 1);
    done   = busy && (cnt == CW'(LAT));
  end

  assert_stall_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);
  assert_done_ends_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: rtl/mul_pipe.sv
module mul_pipe
  import mul_ilk_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  word_t op_a,
  input  word_t op_b,
  input  logic  ovf_en,
  output logic  out_valid,
  output word_t out_prod,
  output logic  out_ovf
);
  localparam int PW = 2 * XLEN;

  logic [PW-1:0]  full;
  logic [LAT-1:0] st_v;
  logic [LAT-1:0] st_o;
  word_t          st_d [LAT];

  always_comb full = {{XLEN{1'b0}}, op_a} * {{XLEN{1'b0}}, op_b};

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_v[0] <= 1'b0;
          st_o[0] <= 1'b0;
          st_d[0] <= '0;
        end else begin
          st_v[0] <= fire;
          if (fire) begin
            st_d[0] <= full[XLEN-1:0];
            st_o[0] <= ovf_en && (|full[PW-1:XLEN]);
          end
        end
      end
    end else begin : g_body
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_v[i] <= 1'b0;
          st_o[i] <= 1'b0;
          st_d[i] <= '0;
        end else begin
          st_v[i] <= st_v[i-1];
          st_o[i] <= st_o[i-1];
          st_d[i] <= st_d[i-1];
        end
      end
    end
  end

  always_comb begin
    out_valid = st_v[LAT-1];
    out_prod  = st_d[LAT-1];
    out_ovf   = st_o[LAT-1] && st_v[LAT-1];
  end
endmodule

// File: rtl/mul_hz.sv
module mul_hz
  import mul_ilk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fire,
  input  ridx_t ex_rd,
  input  logic  busy,
  input  ridx_t rs1,
  input  ridx_t rs2,
  output logic  hazard,
  output ridx_t held_rd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    held_rd <= '0;
    else if (fire) held_rd <= ex_rd;
  end

  logic hit_now, hit_held;
  always_comb begin
    hit_now  = fire && (ex_rd != '0) && ((rs1 == ex_rd) || (rs2 == ex_rd));
    hit_held = busy && (held_rd != '0) && ((rs1 == held_rd) || (rs2 == held_rd));
    hazard   = hit_now || hit_held;
  end

  assert_idle_nohz_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !fire) |-> !hazard);
endmodule

// File: rtl/mul_interlock.sv
module mul_interlock
  import mul_ilk_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_valid,
  output logic        start_ready,
  input  logic [31:0] start_a,
  input  logic [31:0] start_b,
  input  logic [4:0]  start_rd,
  input  logic        start_ovf_en,
  input  logic [4:0]  dec_rs1,
  input  logic [4:0]  dec_rs2,
  input  logic        pipe_wb_valid,
  input  logic [4:0]  pipe_wb_rd,
  input  logic [31:0] pipe_wb_data,
  output logic        stall,
  output logic        hazard,
  output logic        rf_we,
  output logic [4:0]  rf_waddr,
  output logic [31:0] rf_wdata,
  output logic        mul_ovf
);
  logic  busy, sq_bubble, sq_done, fire;
  logic  mp_valid, mp_ovf;
  word_t mp_prod;
  ridx_t held_rd;

  always_comb begin
    start_ready = !busy;
    fire        = start_valid && start_ready;
  end

  mul_seq #(.LAT(LAT)) u_seq (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .busy(busy), .stall(stall), .bubble(sq_bubble), .done(sq_done)
  );

  mul_pipe #(.LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .op_a(start_a), .op_b(start_b), .ovf_en(start_ovf_en),
    .out_valid(mp_valid), .out_prod(mp_prod), .out_ovf(mp_ovf)
  );

  mul_hz u_hz (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ex_rd(start_rd),
    .busy(busy), .rs1(dec_rs1), .rs2(dec_rs2),
    .hazard(hazard), .held_rd(held_rd)
  );

  always_comb begin
    if (sq_done) begin
      rf_we    = (held_rd != '0);
      rf_waddr = held_rd;
      rf_wdata = mp_prod;
    end else begin
      rf_we    = pipe_wb_valid && !sq_bubble;
      rf_waddr = pipe_wb_rd;
      rf_wdata = pipe_wb_data;
    end
    mul_ovf = sq_done && mp_ovf;
  end

  assert_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mp_valid == sq_done);
  assert_ready_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_ready);
  assert_rd0_nowrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_done && held_rd == '0) |-> !rf_we);
  assert_bubble_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_bubble |-> !rf_we);
  assert_ovf_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mul_ovf |-> sq_done);
endmodule

// File: tb/mul_interlock_tb.sv
module mul_interlock_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam int NV = 6;
  // {a, b, rd, ovf_en}
  localparam logic [69:0] VEC [NV] = '{
    {32'h0000_0003, 32'h0000_0005, 5'd1,  1'b0},
    {32'hFFFF_FFFF, 32'h0000_0002, 5'd31, 1'b1},
    {32'h1234_5678, 32'h0000_0000, 5'd9,  1'b1},
    {32'h0001_0000, 32'h0001_0000, 5'd4,  1'b1},
    {32'h0000_0007, 32'h0000_0006, 5'd0,  1'b0},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd12, 1'b0}
  };

  logic clk = 0, rst_n = 0;
  logic start_valid = 0, start_ovf_en = 0;
  logic [31:0] start_a = 0, start_b = 0, pipe_wb_data = 0;
  logic [4:0] start_rd = 0, dec_rs1 = 0, dec_rs2 = 0, pipe_wb_rd = 0;
  logic pipe_wb_valid = 0;
  logic start_ready, stall, hazard, rf_we, mul_ovf;
  logic [4:0] rf_waddr;
  logic [31:0] rf_wdata;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mul_interlock #(.LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_a(start_a), .start_b(start_b), .start_rd(start_rd), .start_ovf_en(start_ovf_en),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .pipe_wb_valid(pipe_wb_valid),
    .pipe_wb_rd(pipe_wb_rd), .pipe_wb_data(pipe_wb_data), .stall(stall),
    .hazard(hazard), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mul_ovf(mul_ovf)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R8 reset state
    chk("R8 ready", start_ready, 1);
    chk("R8 stall", stall, 0);
    chk("R8 hazard", hazard, 0);
    chk("R8 rf_we", rf_we, 0);
    chk("R8 ovf", mul_ovf, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    pipe_wb_valid = 1; pipe_wb_rd = 5'd7; pipe_wb_data = 32'hCAFE_0007;
    #1;
    chk("R5 idle pass we", rf_we, 1);
    chk("R5 idle pass addr", rf_waddr, 7);
    chk("R5 idle pass data", rf_wdata, 32'hCAFE_0007);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] a, b; logic [4:0] rd; logic en; logic [63:0] p;
      {a, b, rd, en} = VEC[v];
      p = {32'b0, a} * {32'b0, b};
      @(negedge clk);
      start_valid = 1; start_a = a; start_b = b; start_rd = rd; start_ovf_en = en;
      dec_rs1 = rd; dec_rs2 = 5'd30;
      #1;
      chk("R1 ready at S", start_ready, 1);
      chk("R6 hazard at S", hazard, (rd != 0));
      for (int k = 1; k <= LAT; k++) begin
        @(negedge clk);
        start_valid = 0; start_a = 32'hDEAD_BEEF; start_rd = 5'd30;
        dec_rs1 = 5'd29; dec_rs2 = rd;
        #1;
        chk("R1 ready busy", start_ready, 0);
        chk("R2 stall window", stall, (k <= LAT - 2));
        chk("R6 hazard busy", hazard, (rd != 0));
        chk("R7 ovf timing", mul_ovf, (k == LAT) && en && (p[63:32] != 0));
        if (k == 1) begin
          chk("R5 older write passes", rf_we, 1);
        end else if (k < LAT) begin
          chk("R5 bubble blocks write", rf_we, 0);
        end else if (rd == 0) begin
          chk("R4 rd0 no write", rf_we, 0);
        end else begin
          chk("R3 we", rf_we, 1);
          chk("R3 addr", rf_waddr, rd);
          chk("R3 data", rf_wdata, p[31:0]);
        end
      end
      @(negedge clk);
      #1;
      chk("R1 ready after", start_ready, 1);
      chk("R2 no stall idle", stall, 0);
      chk("R6 no hazard idle", hazard, 0);
      chk("R5 pass after", rf_we, 1);
    end

    // R6 nonmatching source gives no hazard during busy
    @(negedge clk);
    start_valid = 1; start_a = 2; start_b = 3; start_rd = 5'd8; start_ovf_en = 0;
    dec_rs1 = 5'd1; dec_rs2 = 5'd2;
    #1;
    chk("R6 no match at S", hazard, 0);
    @(negedge clk); start_valid = 0; #1;
    chk("R6 no match busy", hazard, 0);
    dec_rs1 = 5'd8; #1;
    chk("R6 rs1 match busy", hazard, 1);
    repeat (LAT) @(negedge clk);
    #1;
    chk("R1 ready after last", start_ready, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule